// File: doc/BRIEF.md
# Byte-Lane EDO DRAM Cycle Decoder

This block is a synthesizable, clocked behavioural model of a 16-bit extended-data-out DRAM. It is meant to sit in a testbench as the target of a DRAM controller. On every clock edge it samples the row strobe, the two byte-lane column strobes, write enable, output enable and the multiplexed address, all active low. It works out the cycle type from the order in which those strobes change. The types are read, early write, late write, read-modify-write, row-only refresh, refresh with the column strobe first, and hidden refresh. The model then updates a small internal word array, one byte lane at a time.

The row address is captured when the row strobe falls. The column address is captured when the first column strobe falls. The array index takes the low bits of both. The lower data byte belongs to the lower-lane strobe and the upper byte to the upper-lane strobe. Read data stays on the outputs after the column strobes rise, in the extended-data-out manner, until a defined clearing event. Every classified cycle produces a one-clock report. A cycle that cannot be classified raises an error pulse.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `edo_byte_dram_model`

## Requirements
- R1: A row-strobe fall while either column strobe is low and no read data is held reports kind 6. It also increments `refresh_row` by one and leaves the array unchanged.
- R2: Write enable low when the first column strobe falls reports kind 2. The write stores `dq_in` into each lane whose strobe falls during that access, and `dq_drive` stays 0.
- R3: Write enable falls during a read with a column strobe low and output enable high, and no data was driven earlier in that access. This reports kind 3 and stores `dq_in`, as sampled at that edge, into every lane whose strobe is low.
- R4: The same write enable fall, made after data was driven with output enable low in that access, reports kind 4 (read-modify-write) and performs the same store.
- R5: A read reports kind 1. `dq_out[7:0]` belongs to the lower strobe `cas_lo_n` and `dq_out[15:8]` to the upper strobe `cas_hi_n`. Bit i of `dq_drive` is set only for a lane whose strobe fell in this access, and only while output enable is low.
- R6: Read data and drive remain after the column strobes rise while the row strobe is low. They clear once the row strobe and both column strobes are high, or when write enable falls.
- R7: Output enable rising clears the drive. Taking output enable low again in the same access does not restore it.
- R8: A row-strobe fall with a column strobe low while read data is held reports kind 7 (hidden refresh). It increments `refresh_row` and keeps driving the held data.
- R9: The row strobe falling and then rising with no column strobe fall in between reports kind 5 at the rise.
- R10: Write enable falling during a read while output enable is low pulses `order_err` for one clock. No kind is reported and no array write takes place.
- R11: The word index is {row[HI-1:0], col[LO-1:0]}, with LO = DEPTH_W/2 and HI = DEPTH_W-LO. With the default of 3+3, addresses that differ only above those bits alias.
- R12: Repeated column strobe cycles under one row strobe each capture a new column and report their own kind.
- R13: After reset, `dq_drive`, `cyc_valid`, `order_err` and `refresh_row` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Column strobe for the low byte, active low |
| cas_hi_n | input | 1 | Column strobe for the high byte, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row and column address |
| dq_in | input | 2*LANE_W | Write data |
| dq_out | output | 2*LANE_W | Read data, held in the extended-data-out manner |
| dq_drive | output | 2 | Per-lane output drive enable |
| cyc_valid | output | 1 | One-clock report that a cycle was classified |
| cyc_kind | output | 3 | Kind: 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 strobe-first refresh, 7 hidden refresh |
| order_err | output | 1 | One-clock pulse for an unclassifiable edge order |
| refresh_row | output | ADDR_W | Internal refresh row counter |

## Verification
Two functions can land on the same clock edge. A refresh is classified on the row-strobe fall while earlier read data is still being driven through the same edge. The bench provokes this by keeping both column strobes low across a row-strobe high pulse after a read. It then checks that the hidden-refresh kind is reported, that the counter advances, and that `dq_out` and `dq_drive` are unchanged in the same sample. The second overlap is between write enable falling and the clearing of held read data. This is judged by checking in one sample that the late-write or read-modify-write kind is reported, that the drive has dropped, and, through a later read, that the array has taken the new data.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_READ    = 3'd1,
    K_EWRITE  = 3'd2,
    K_LWRITE  = 3'd3,
    K_RMW     = 3'd4,
    K_RASREF  = 3'd5,
    K_CBR     = 3'd6,
    K_HIDDEN  = 3'd7
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_READ,
    PH_EWR,
    PH_LWR,
    PH_REF
  } phase_e;

  // Word index: low row bits on top, low column bits below.
  function automatic int unsigned mem_index(int unsigned row, int unsigned col,
                                            int unsigned dw);
    int unsigned lo;
    int unsigned hi;
    lo = dw / 2;
    hi = dw - lo;
    return ((row & ((32'd1 << hi) - 1)) << lo) | (col & ((32'd1 << lo) - 1));
  endfunction

endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic [1:0] cas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       ras_fall,
  output logic       ras_rise,
  output logic [1:0] lane_fall,
  output logic       first_fall,
  output logic       last_rise,
  output logic       we_fall,
  output logic       oe_rise
);
  logic       p_ras_n;
  logic [1:0] p_cas_n;
  logic       p_we_n;
  logic       p_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ras_n <= 1'b1;
      p_cas_n <= 2'b11;
      p_we_n  <= 1'b1;
      p_oe_n  <= 1'b1;
    end else begin
      p_ras_n <= ras_n;
      p_cas_n <= cas_n;
      p_we_n  <= we_n;
      p_oe_n  <= oe_n;
    end
  end

  assign ras_fall   = p_ras_n & ~ras_n;
  assign ras_rise   = ~p_ras_n & ras_n;
  assign lane_fall  = p_cas_n & ~cas_n;
  assign first_fall = (&p_cas_n) & ~(&cas_n);
  assign last_rise  = ~(&p_cas_n) & (&cas_n);
  assign we_fall    = p_we_n & ~we_n;
  assign oe_rise    = ~p_oe_n & oe_n;
endmodule

// File: rtl/edo_cycle_ctrl.sv
module edo_cycle_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic [1:0]        lane_fall,
  input  logic              first_fall,
  input  logic              last_rise,
  input  logic              we_fall,
  input  logic              hold_any,
  output logic [1:0]        wr_lane,
  output logic [1:0]        ld_lane,
  output logic [1:0]        kill_lane,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_eff,
  output logic              cyc_valid,
  output logic [2:0]        cyc_kind,
  output logic              order_err,
  output logic [ADDR_W-1:0] ref_row
);
  phase_e            phase_q, phase_n;
  logic [ADDR_W-1:0] col_q;
  logic              accessed_q, accessed_n;
  logic              rd_seen_q, rd_seen_n;
  logic              ref_inc, row_load, err_n;
  cyc_kind_e         kind_n;

  assign col_eff = first_fall ? addr : col_q;

  always_comb begin
    phase_n    = phase_q;
    accessed_n = accessed_q;
    rd_seen_n  = rd_seen_q;
    wr_lane    = 2'b00;
    ld_lane    = 2'b00;
    kill_lane  = 2'b00;
    kind_n     = K_NONE;
    err_n      = 1'b0;
    ref_inc    = 1'b0;
    row_load   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (ras_fall) begin
          if (~&cas_n) begin
            ref_inc = 1'b1;
            kind_n  = hold_any ? K_HIDDEN : K_CBR;
            phase_n = PH_REF;
          end else begin
            row_load   = 1'b1;
            accessed_n = 1'b0;
            phase_n    = PH_ROW;
          end
        end
      end
      PH_REF: if (ras_rise) phase_n = PH_IDLE;
      PH_ROW: begin
        if (ras_rise) begin
          phase_n = PH_IDLE;
          if (!accessed_q) kind_n = K_RASREF;
        end else if (first_fall) begin
          accessed_n = 1'b1;
          rd_seen_n  = 1'b0;
          if (!we_n) begin
            phase_n = PH_EWR;
            kind_n  = K_EWRITE;
            wr_lane = lane_fall;
          end else begin
            phase_n   = PH_READ;
            kind_n    = K_READ;
            ld_lane   = lane_fall;
            kill_lane = ~lane_fall;
          end
        end
      end
      PH_READ: begin
        if (ras_rise) phase_n = PH_IDLE;
        else if (last_rise) phase_n = PH_ROW;
        else if (we_fall) begin
          phase_n = PH_LWR;
          if (oe_n) begin
            kind_n  = rd_seen_q ? K_RMW : K_LWRITE;
            wr_lane = ~cas_n;
          end else begin
            err_n = 1'b1;
          end
        end else begin
          ld_lane = lane_fall;
          if (!oe_n && hold_any) rd_seen_n = 1'b1;
        end
      end
      PH_EWR: begin
        if (ras_rise) phase_n = PH_IDLE;
        else if (last_rise) phase_n = PH_ROW;
        else wr_lane = lane_fall;
      end
      PH_LWR: begin
        if (ras_rise) phase_n = PH_IDLE;
        else if (last_rise) phase_n = PH_ROW;
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      accessed_q <= 1'b0;
      rd_seen_q  <= 1'b0;
      ref_row    <= '0;
      cyc_valid  <= 1'b0;
      cyc_kind   <= K_NONE;
      order_err  <= 1'b0;
    end else begin
      phase_q    <= phase_n;
      accessed_q <= accessed_n;
      rd_seen_q  <= rd_seen_n;
      if (row_load) row_q <= addr;
      if (first_fall) col_q <= addr;
      if (ref_inc) ref_row <= ref_row + 1'b1;
      cyc_valid  <= (kind_n != K_NONE);
      cyc_kind   <= kind_n;
      order_err  <= err_n;
    end
  end
endmodule

// File: rtl/edo_lane_store.sv
module edo_lane_store #(
  parameter int ADDR_W  = 10,
  parameter int LANE_W  = 8,
  parameter int DEPTH_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          wr_lane,
  input  logic [1:0]          ld_lane,
  input  logic [1:0]          kill_lane,
  input  logic                clr_all,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   row,
  input  logic [ADDR_W-1:0]   col,
  input  logic [2*LANE_W-1:0] dq_in,
  output logic [2*LANE_W-1:0] dq_out,
  output logic [1:0]          dq_drive,
  output logic                hold_any
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [DEPTH_W-1:0] idx;
  logic [1:0]         hold_q;

  assign idx      = DEPTH_W'(edo_pkg::mem_index(32'(row), 32'(col), DEPTH_W));
  assign hold_any = |hold_q;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] data_q;
    logic              hold_n;

    always_comb begin
      hold_n = hold_q[g];
      if (clr_all || kill_lane[g]) hold_n = 1'b0;
      else if (ld_lane[g])         hold_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
        data_q      <= '0;
        hold_q[g]   <= 1'b0;
        dq_drive[g] <= 1'b0;
      end else begin
        if (wr_lane[g]) bank[idx] <= dq_in[g*LANE_W +: LANE_W];
        if (ld_lane[g] && !clr_all) data_q <= bank[idx];
        hold_q[g]   <= hold_n;
        dq_drive[g] <= hold_n & ~oe_n;
      end
    end

    assign dq_out[g*LANE_W +: LANE_W] = data_q;
  end
endmodule

// File: rtl/edo_byte_dram_model.sv
module edo_byte_dram_model #(
  parameter int ADDR_W  = 10,
  parameter int LANE_W  = 8,
  parameter int DEPTH_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_lo_n,
  input  logic                cas_hi_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*LANE_W-1:0] dq_in,
  output logic [2*LANE_W-1:0] dq_out,
  output logic [1:0]          dq_drive,
  output logic                cyc_valid,
  output logic [2:0]          cyc_kind,
  output logic                order_err,
  output logic [ADDR_W-1:0]   refresh_row
);
  logic [1:0]        cas_n;
  logic              ras_fall, ras_rise, first_fall, last_rise, we_fall, oe_rise;
  logic [1:0]        lane_fall, wr_lane, ld_lane, kill_lane;
  logic              hold_any, clr_all;
  logic [ADDR_W-1:0] row_q, col_eff;

  assign cas_n   = {cas_hi_n, cas_lo_n};
  assign clr_all = (ras_n & (&cas_n)) | oe_rise | we_fall;

  edo_strobe_sampler u_smp (
    .clk, .rst_n, .ras_n, .cas_n, .we_n, .oe_n,
    .ras_fall, .ras_rise, .lane_fall, .first_fall, .last_rise, .we_fall, .oe_rise
  );

  edo_cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk, .rst_n, .cas_n, .we_n, .oe_n, .addr,
    .ras_fall, .ras_rise, .lane_fall, .first_fall, .last_rise, .we_fall, .hold_any,
    .wr_lane, .ld_lane, .kill_lane, .row_q, .col_eff,
    .cyc_valid, .cyc_kind, .order_err, .ref_row(refresh_row)
  );

  edo_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .DEPTH_W(DEPTH_W)) u_sto (
    .clk, .rst_n, .wr_lane, .ld_lane, .kill_lane, .clr_all, .oe_n,
    .row(row_q), .col(col_eff), .dq_in, .dq_out, .dq_drive, .hold_any
  );
endmodule

// File: rtl/edo_byte_dram_model_sva.sv
module edo_byte_dram_model_sva #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_lo_n,
  input logic              cas_hi_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [1:0]        dq_drive,
  input logic              cyc_valid,
  input logic [2:0]        cyc_kind,
  input logic              order_err,
  input logic [ADDR_W-1:0] refresh_row
);
  a_r1_count_only_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_row != $past(refresh_row)) |-> (cyc_valid && (cyc_kind == 3'd6 || cyc_kind == 3'd7)));

  a_r8_refresh_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_kind == 3'd6 || cyc_kind == 3'd7)) |-> (refresh_row == ADDR_W'($past(refresh_row) + 1'b1)));

  a_r2_early_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == 3'd2) |-> (dq_drive == 2'b00));

  a_r3_late_write_order: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_kind == 3'd3 || cyc_kind == 3'd4)) |-> ($past(oe_n) && !$past(we_n)));

  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_lo_n && cas_hi_n) |=> (dq_drive == 2'b00));

  a_r6_we_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |=> (dq_drive == 2'b00));

  a_r5_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_drive != 2'b00) |-> !$past(oe_n));

  a_r10_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |-> !cyc_valid);
endmodule

bind edo_byte_dram_model edo_byte_dram_model_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
  .we_n(we_n), .oe_n(oe_n), .dq_drive(dq_drive), .cyc_valid(cyc_valid),
  .cyc_kind(cyc_kind), .order_err(order_err), .refresh_row(refresh_row)
);

// File: tb/edo_byte_dram_model_tb_top.sv
module edo_byte_dram_model_tb_top;
  localparam int AW = 10;
  localparam int DW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_drive;
  logic        cyc_valid, order_err;
  logic [2:0]  cyc_kind;
  logic [AW-1:0] refresh_row;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] exp_mem [64];
  int unsigned exp_ref = 0;

  always #2 clk = ~clk;

  edo_byte_dram_model dut_i (
    .clk, .rst_n, .ras_n, .cas_lo_n, .cas_hi_n, .we_n, .oe_n, .addr, .dq_in,
    .dq_out, .dq_drive, .cyc_valid, .cyc_kind, .order_err, .refresh_row
  );

  function automatic int unsigned word_at(int unsigned row, int unsigned col);
    return (row % 8) * 8 + (col % 8);
  endfunction

  function automatic logic [15:0] lane_merge(logic [15:0] old, logic [15:0] nw, logic [1:0] m);
    logic [15:0] r;
    r = old;
    if (m[0]) r[7:0]  = nw[7:0];
    if (m[1]) r[15:8] = nw[15:8];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_kind(string req, int k);
    chk(req, {cyc_valid, cyc_kind}, (k == 0) ? 32'h0 : (32'h8 | k));
  endtask

  task automatic release_all();
    cas_lo_n = 1; cas_hi_n = 1; we_n = 1; oe_n = 1; ras_n = 1;
    tick();
    tick();
  endtask

  task automatic early_write(int unsigned row, int unsigned col, logic [1:0] m, logic [15:0] d,
                             bit verify);
    ras_n = 0; addr = AW'(row); tick();
    we_n = 0; addr = AW'(col); dq_in = d; tick();
    cas_lo_n = ~m[0]; cas_hi_n = ~m[1]; tick();
    if (verify) begin
      chk_kind("R2 early-write kind", 2);
      chk("R2 early-write no drive", dq_drive, 0);
    end
    exp_mem[word_at(row, col)] = lane_merge(exp_mem[word_at(row, col)], d, m);
    release_all();
  endtask

  task automatic read_word(string req, int unsigned row, int unsigned col, logic [1:0] m);
    logic [15:0] e;
    e = exp_mem[word_at(row, col)];
    ras_n = 0; addr = AW'(row); tick();
    addr = AW'(col); cas_lo_n = ~m[0]; cas_hi_n = ~m[1]; oe_n = 0; tick();
    chk({req, " read kind"}, {cyc_valid, cyc_kind}, 32'h9);
    chk({req, " drive"}, dq_drive, m);
    if (m[0]) chk({req, " low byte"}, dq_out[7:0], e[7:0]);
    if (m[1]) chk({req, " high byte"}, dq_out[15:8], e[15:8]);
    release_all();
  endtask

  initial begin
    void'($urandom(32'd7781));
    for (int i = 0; i < 64; i++) exp_mem[i] = '0;
    repeat (3) tick();
    rst_n = 1; tick();
    // R13 reset state
    chk("R13 drive", dq_drive, 0);
    chk("R13 valid", cyc_valid, 0);
    chk("R13 err", order_err, 0);
    chk("R13 refresh_row", refresh_row, 0);

    // R2 early write, both lanes, then R5 lane reads
    early_write(2, 5, 2'b11, 16'hA55A, 1);
    read_word("R5 both lanes", 2, 5, 2'b11);
    read_word("R5 low lane only", 2, 5, 2'b01);
    read_word("R5 high lane only", 2, 5, 2'b10);
    // R2 byte write of the upper lane only
    early_write(2, 5, 2'b10, 16'h3CFF, 1);
    read_word("R2 byte write merge", 2, 5, 2'b11);

    // R11 aliasing: row+8 / col+8 hits the same word
    early_write(1, 3, 2'b11, 16'h1234, 1);
    read_word("R11 alias", 9, 11, 2'b11);

    // R6 EDO hold and clear
    ras_n = 0; addr = 10'd2; tick();
    addr = 10'd5; cas_lo_n = 0; cas_hi_n = 0; oe_n = 0; tick();
    cas_lo_n = 1; cas_hi_n = 1; tick();
    chk("R6 hold after CAS rise", dq_drive, 2'b11);
    chk("R6 held data", dq_out, exp_mem[word_at(2, 5)]);
    ras_n = 1; tick();
    chk("R6 clear when all strobes high", dq_drive, 0);
    release_all();

    // R6 WE fall clears held data (page-open state)
    ras_n = 0; addr = 10'd2; tick();
    addr = 10'd5; cas_lo_n = 0; cas_hi_n = 0; oe_n = 0; tick();
    cas_lo_n = 1; cas_hi_n = 1; tick();
    we_n = 0; tick();
    chk("R6 clear on WE fall", dq_drive, 0);
    release_all();

    // R7 OE rise clears, OE low again does not restore
    ras_n = 0; addr = 10'd2; tick();
    addr = 10'd5; cas_lo_n = 0; cas_hi_n = 0; oe_n = 0; tick();
    oe_n = 1; tick();
    chk("R7 OE rise clears", dq_drive, 0);
    oe_n = 0; tick();
    chk("R7 no restore", dq_drive, 0);
    release_all();

    // R3 late write
    ras_n = 0; addr = 10'd4; tick();
    addr = 10'd6; cas_lo_n = 0; cas_hi_n = 0; oe_n = 1; tick();
    chk_kind("R3 starts as read", 1);
    dq_in = 16'hBEEF; we_n = 0; tick();
    chk_kind("R3 late-write kind", 3);
    exp_mem[word_at(4, 6)] = 16'hBEEF;
    release_all();
    read_word("R3 late-write data", 4, 6, 2'b11);

    // R4 read-modify-write on the low lane only
    ras_n = 0; addr = 10'd4; tick();
    addr = 10'd6; cas_lo_n = 0; oe_n = 0; tick();
    chk("R4 read phase data", dq_out[7:0], 8'hEF);
    tick();
    oe_n = 1; tick();
    dq_in = 16'h7711; we_n = 0; tick();
    chk_kind("R4 rmw kind", 4);
    chk("R4 no drive during write", dq_drive, 0);
    exp_mem[word_at(4, 6)] = lane_merge(exp_mem[word_at(4, 6)], 16'h7711, 2'b01);
    release_all();
    read_word("R4 rmw data", 4, 6, 2'b11);

    // R10 order error
    ras_n = 0; addr = 10'd4; tick();
    addr = 10'd6; cas_lo_n = 0; cas_hi_n = 0; oe_n = 0; tick();
    dq_in = 16'h0000; we_n = 0; tick();
    chk("R10 err pulse", order_err, 1);
    chk("R10 no kind", cyc_valid, 0);
    tick();
    chk("R10 err one clock", order_err, 0);
    release_all();
    read_word("R10 array unchanged", 4, 6, 2'b11);

    // R1 strobe-first refresh
    cas_lo_n = 0; cas_hi_n = 0; tick();
    ras_n = 0; tick();
    exp_ref++;
    chk_kind("R1 refresh kind", 6);
    chk("R1 counter", refresh_row, exp_ref);
    release_all();
    read_word("R1 array unchanged", 4, 6, 2'b11);

    // R9 row-only refresh
    ras_n = 0; addr = 10'd9; tick();
    chk_kind("R9 nothing at fall", 0);
    ras_n = 1; tick();
    chk_kind("R9 row-only refresh kind", 5);
    chk("R9 counter untouched", refresh_row, exp_ref);
    release_all();

    // R8 hidden refresh: overlaps held read data with a refresh
    ras_n = 0; addr = 10'd2; tick();
    addr = 10'd5; cas_lo_n = 0; cas_hi_n = 0; oe_n = 0; tick();
    ras_n = 1; tick();
    ras_n = 0; tick();
    exp_ref++;
    chk_kind("R8 hidden kind", 7);
    chk("R8 counter", refresh_row, exp_ref);
    chk("R8 still driving", dq_drive, 2'b11);
    chk("R8 data kept", dq_out, exp_mem[word_at(2, 5)]);
    release_all();

    // R12 page mode: two columns in one row access
    early_write(3, 1, 2'b11, 16'h1111, 0);
    early_write(3, 2, 2'b11, 16'h2222, 0);
    ras_n = 0; addr = 10'd3; tick();
    addr = 10'd1; cas_lo_n = 0; cas_hi_n = 0; oe_n = 0; tick();
    chk("R12 first column", dq_out, 16'h1111);
    cas_lo_n = 1; cas_hi_n = 1; tick();
    addr = 10'd2; cas_lo_n = 0; cas_hi_n = 0; tick();
    chk_kind("R12 second read kind", 1);
    chk("R12 second column", dq_out, 16'h2222);
    release_all();

    // Random early writes and reads (R2, R5, R11)
    for (int i = 0; i < 40; i++) begin
      int unsigned r, c;
      logic [1:0] m;
      r = $urandom % 1024;
      c = $urandom % 1024;
      m = 2'($urandom % 3 + 1);
      if ($urandom % 2) early_write(r, c, m, 16'($urandom), 0);
      else read_word("R5 random", r, c, 2'b11);
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule